// File: doc/BRIEF.md
# Picture Frame Overlay Generator

This block marks a rectangular window over the active picture and produces the colour to insert there. The horizontal and vertical pixel positions come from the display timing counters. Four 9-bit window values set the left, right, top and bottom edges of the rectangle. Two horizontal codes are reserved: zero turns the frame off, and all ones makes the frame cover the whole screen. A top-edge value of zero also turns the frame off.

Each colour channel (red, green, blue) has an 8-bit frame colour and a 4-bit contrast code. The insertion amplitude for a channel is the colour multiplied by (code + 4), clamped to 255. Codes 14 and 15 are illegal. For an illegal code the block reports the channel as not valid and drives its amplitude to zero.

Every output is a flop, so results appear one clock after the inputs are presented. The asynchronous active-low reset is released through a two-stage synchronizer. Priority against other overlay sources is decided outside the block.

Top module: `pframe_overlay`

## Requirements
- R1: Each output reflects the inputs sampled at the previous rising clock edge, so there is one cycle of latency. Changing the inputs between edges leaves the outputs unchanged.
- R2: While reset is asserted, `frame_act`, all three amplitudes and all three valid flags are 0.
- R3: For a contrast code from 0 to 13 where colour × (code + 4) is at most 255, the channel amplitude equals that product.
- R4: For a contrast code from 0 to 13 where colour × (code + 4) exceeds 255, the channel amplitude is 255.
- R5: A contrast code of 14 or 15 drives that channel's valid flag to 0 and its amplitude to 0. Codes 0 to 13 drive the valid flag to 1.
- R6: With the horizontal begin value neither 0 nor 0x1FF, and the vertical begin value not 0, `frame_act` is 1 exactly when both hold: begin ≤ h_pos < end horizontally, and begin ≤ v_pos < end vertically. Begin is inclusive and end is exclusive.
- R7: A horizontal begin value of 0 forces `frame_act` to 0 for any position and any other window value.
- R8: A horizontal begin value of 0x1FF forces `frame_act` to 1 for any position and any other window value, including a vertical begin value of 0.
- R9: A vertical begin value of 0 forces `frame_act` to 0 unless R8 applies.
- R10: Each channel's amplitude and valid flag depend only on that channel's own colour and code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| arst_n | input | 1 | Asynchronous reset, active low; released synchronously inside the block |
| h_pos | input | 9 | Horizontal position counter |
| v_pos | input | 9 | Vertical position counter |
| h_beg | input | 9 | Horizontal begin (0 = off, 0x1FF = full screen) |
| h_end | input | 9 | Horizontal end (exclusive) |
| v_beg | input | 9 | Vertical begin (0 = off) |
| v_end | input | 9 | Vertical end (exclusive) |
| col_r | input | 8 | Frame colour, red |
| col_g | input | 8 | Frame colour, green |
| col_b | input | 8 | Frame colour, blue |
| code_r | input | 4 | Contrast code, red |
| code_g | input | 4 | Contrast code, green |
| code_b | input | 4 | Contrast code, blue |
| frame_act | output | 1 | Position lies inside the frame |
| amp_r | output | 8 | Scaled red amplitude |
| amp_g | output | 8 | Scaled green amplitude |
| amp_b | output | 8 | Scaled blue amplitude |
| vld_r | output | 1 | Red contrast code is legal |
| vld_g | output | 1 | Green contrast code is legal |
| vld_b | output | 1 | Blue contrast code is legal |

## Verification
The assertions check the following on every cycle:
- the horizontal-off, full-screen and vertical-off overrides on the next cycle's `frame_act`;
- the right-edge exclusion;
- the illegal-code zeroing and the valid flag;
- the zero-colour case;
- saturation whenever the colour alone guarantees overflow.

Only the bench's scenarios can show the following:
- exact products below the clamp, and clamping at the 255/256 boundary;
- inclusive begin and exclusive end at the exact edge values;
- the one-cycle latency when inputs change between edges;
- independence of the three channels under mixed codes;
- the reset values.

// File: rtl/pframe_pkg.sv
package pframe_pkg;
  localparam int unsigned POS_W     = 9;
  localparam int unsigned COL_W     = 8;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned CODE_BIAS = 4;
  localparam int unsigned CODE_LAST = 13;
  localparam int unsigned NUM_CH    = 3;

  typedef enum logic [1:0] {
    WIN_OFF   = 2'd0,
    WIN_FULL  = 2'd1,
    WIN_RANGE = 2'd2
  } win_mode_e;
endpackage

// File: rtl/pframe_rst_sync.sv
module pframe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pframe_window.sv
module pframe_window
  import pframe_pkg::*;
#(
  parameter int unsigned P_W = POS_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [P_W-1:0] h_pos,
  input  logic [P_W-1:0] v_pos,
  input  logic [P_W-1:0] h_beg,
  input  logic [P_W-1:0] h_end,
  input  logic [P_W-1:0] v_beg,
  input  logic [P_W-1:0] v_end,
  output logic           act_q
);
  localparam logic [P_W-1:0] H_FULL = {P_W{1'b1}};

  win_mode_e mode;
  logic      h_in, v_in, act_d;

  always_comb begin
    if (h_beg == H_FULL)                   mode = WIN_FULL;
    else if (h_beg == '0 || v_beg == '0)   mode = WIN_OFF;
    else                                   mode = WIN_RANGE;
  end

  always_comb begin
    h_in = (h_pos >= h_beg) && (h_pos < h_end);
    v_in = (v_pos >= v_beg) && (v_pos < v_end);
    unique case (mode)
      WIN_FULL:  act_d = 1'b1;
      WIN_RANGE: act_d = h_in && v_in;
      default:   act_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assert_hoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (h_beg == '0) |=> !act_q);
  assert_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_beg == H_FULL) |=> act_q);
  assert_voff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (v_beg == '0 && h_beg != H_FULL) |=> !act_q);
  assert_hend_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (h_beg != H_FULL && h_pos >= h_end) |=> !act_q);
endmodule

// File: rtl/pframe_chan_scale.sv
module pframe_chan_scale
  import pframe_pkg::*;
#(
  parameter int unsigned C_W  = COL_W,
  parameter int unsigned K_W  = CODE_W,
  parameter int unsigned BIAS = CODE_BIAS,
  parameter int unsigned LAST = CODE_LAST
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [C_W-1:0] color,
  input  logic [K_W-1:0] code,
  output logic [C_W-1:0] amp_q,
  output logic           vld_q
);
  localparam int unsigned   G_W    = K_W + 1;
  localparam int unsigned   PROD_W = C_W + G_W;
  localparam logic [K_W-1:0] LAST_C = K_W'(LAST);

  logic              code_ok;
  logic [G_W-1:0]    gain;
  logic [PROD_W-1:0] prod;
  logic [C_W-1:0]    amp_d;

  always_comb begin
    code_ok = (code <= LAST_C);
    gain    = {1'b0, code} + G_W'(BIAS);
    prod    = PROD_W'(color) * PROD_W'(gain);
    if (!code_ok)                      amp_d = '0;
    else if (|prod[PROD_W-1:C_W])      amp_d = {C_W{1'b1}};
    else                               amp_d = prod[C_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amp_q <= '0;
      vld_q <= 1'b0;
    end else begin
      amp_q <= amp_d;
      vld_q <= code_ok;
    end
  end

  assert_bad_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (code > LAST_C) |=> (amp_q == '0 && !vld_q));
  assert_good_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (code <= LAST_C) |=> vld_q);
  assert_zero_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (color == '0) |=> (amp_q == '0));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (code <= LAST_C && color[C_W-1:C_W-2] != 2'b00) |=> (amp_q == {C_W{1'b1}}));
endmodule

// File: rtl/pframe_overlay.sv
module pframe_overlay
  import pframe_pkg::*;
(
  input  logic               clk,
  input  logic               arst_n,
  input  logic [POS_W-1:0]   h_pos,
  input  logic [POS_W-1:0]   v_pos,
  input  logic [POS_W-1:0]   h_beg,
  input  logic [POS_W-1:0]   h_end,
  input  logic [POS_W-1:0]   v_beg,
  input  logic [POS_W-1:0]   v_end,
  input  logic [COL_W-1:0]   col_r,
  input  logic [COL_W-1:0]   col_g,
  input  logic [COL_W-1:0]   col_b,
  input  logic [CODE_W-1:0]  code_r,
  input  logic [CODE_W-1:0]  code_g,
  input  logic [CODE_W-1:0]  code_b,
  output logic               frame_act,
  output logic [COL_W-1:0]   amp_r,
  output logic [COL_W-1:0]   amp_g,
  output logic [COL_W-1:0]   amp_b,
  output logic               vld_r,
  output logic               vld_g,
  output logic               vld_b
);
  logic rst_n;

  logic [NUM_CH-1:0][COL_W-1:0]  col_a;
  logic [NUM_CH-1:0][CODE_W-1:0] code_a;
  logic [NUM_CH-1:0][COL_W-1:0]  amp_a;
  logic [NUM_CH-1:0]             vld_a;

  pframe_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  pframe_window #(.P_W(POS_W)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .h_pos (h_pos),
    .v_pos (v_pos),
    .h_beg (h_beg),
    .h_end (h_end),
    .v_beg (v_beg),
    .v_end (v_end),
    .act_q (frame_act)
  );

  assign col_a  = {col_b, col_g, col_r};
  assign code_a = {code_b, code_g, code_r};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    pframe_chan_scale #(
      .C_W  (COL_W),
      .K_W  (CODE_W),
      .BIAS (CODE_BIAS),
      .LAST (CODE_LAST)
    ) u_scale (
      .clk   (clk),
      .rst_n (rst_n),
      .color (col_a[ch]),
      .code  (code_a[ch]),
      .amp_q (amp_a[ch]),
      .vld_q (vld_a[ch])
    );
  end

  assign amp_r = amp_a[0];
  assign amp_g = amp_a[1];
  assign amp_b = amp_a[2];
  assign vld_r = vld_a[0];
  assign vld_g = vld_a[1];
  assign vld_b = vld_a[2];
endmodule

// File: tb/pframe_overlay_tb.sv
module pframe_overlay_tb;
  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic [8:0] h_pos, v_pos, h_beg, h_end, v_beg, v_end;
  logic [7:0] col_r, col_g, col_b;
  logic [3:0] code_r, code_g, code_b;
  logic       frame_act, vld_r, vld_g, vld_b;
  logic [7:0] amp_r, amp_g, amp_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pframe_overlay u_dut (
    .clk(clk), .arst_n(arst_n), .h_pos(h_pos), .v_pos(v_pos),
    .h_beg(h_beg), .h_end(h_end), .v_beg(v_beg), .v_end(v_end),
    .col_r(col_r), .col_g(col_g), .col_b(col_b),
    .code_r(code_r), .code_g(code_g), .code_b(code_b),
    .frame_act(frame_act), .amp_r(amp_r), .amp_g(amp_g), .amp_b(amp_b),
    .vld_r(vld_r), .vld_g(vld_g), .vld_b(vld_b)
  );

  function automatic logic [7:0] m_amp(input logic [7:0] c, input logic [3:0] k);
    int p;
    if (k > 4'd13) return 8'd0;
    p = int'(c) * (int'(k) + 4);
    return (p > 255) ? 8'd255 : 8'(p);
  endfunction

  function automatic logic m_act(input logic [8:0] h, v, hb, he, vb, ve);
    if (hb == 9'h1FF) return 1'b1;
    if (hb == 9'd0 || vb == 9'd0) return 1'b0;
    return (h >= hb) && (h < he) && (v >= vb) && (v < ve);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [8:0] h, v, hb, he, vb, ve,
                       input logic [7:0] cr, cg, cb, input logic [3:0] kr, kg, kb);
    h_pos = h; v_pos = v; h_beg = hb; h_end = he; v_beg = vb; v_end = ve;
    col_r = cr; col_g = cg; col_b = cb; code_r = kr; code_g = kg; code_b = kb;
  endtask

  task automatic check_all(input string req);
    chk({req, " act"}, 32'(frame_act), 32'(m_act(h_pos, v_pos, h_beg, h_end, v_beg, v_end)));
    chk({req, " amp_r"}, 32'(amp_r), 32'(m_amp(col_r, code_r)));
    chk({req, " amp_g"}, 32'(amp_g), 32'(m_amp(col_g, code_g)));
    chk({req, " amp_b"}, 32'(amp_b), 32'(m_amp(col_b, code_b)));
    chk({req, " vld_r"}, 32'(vld_r), 32'(code_r <= 4'd13));
    chk({req, " vld_g"}, 32'(vld_g), 32'(code_g <= 4'd13));
    chk({req, " vld_b"}, 32'(vld_b), 32'(code_b <= 4'd13));
  endtask

  // apply at negedge, check one negedge later (one posedge between)
  task automatic step(input string req,
                      input logic [8:0] h, v, hb, he, vb, ve,
                      input logic [7:0] cr, cg, cb, input logic [3:0] kr, kg, kb);
    @(negedge clk);
    drive(h, v, hb, he, vb, ve, cr, cg, cb, kr, kg, kb);
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [8:0] o_h, o_hb;
    int seed;
    drive(9'd5, 9'd5, 9'd1, 9'd10, 9'd1, 9'd10, 8'd50, 8'd50, 8'd50, 4'd3, 4'd3, 4'd3);
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 act", 32'(frame_act), 0);
    chk("R2 amp_r", 32'(amp_r), 0);
    chk("R2 amp_g", 32'(amp_g), 0);
    chk("R2 amp_b", 32'(amp_b), 0);
    chk("R2 vld", 32'({vld_r, vld_g, vld_b}), 0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 exact products, R10 independent channels
    step("R3", 9'd5, 9'd5, 9'd2, 9'd9, 9'd3, 9'd8, 8'd15, 8'd0, 8'd10, 4'd13, 4'd0, 4'd7);
    step("R10", 9'd5, 9'd5, 9'd2, 9'd9, 9'd3, 9'd8, 8'd63, 8'd200, 8'd1, 4'd0, 4'd15, 4'd13);
    // R4 saturation boundary
    step("R4", 9'd0, 9'd0, 9'd2, 9'd9, 9'd3, 9'd8, 8'd64, 8'd16, 8'd255, 4'd0, 4'd13, 4'd13);
    // R5 invalid codes
    step("R5", 9'd0, 9'd0, 9'd2, 9'd9, 9'd3, 9'd8, 8'd100, 8'd100, 8'd100, 4'd14, 4'd15, 4'd12);
    // R6 inclusive begin, exclusive end
    step("R6 hbeg", 9'd2, 9'd3, 9'd2, 9'd9, 9'd3, 9'd8, 8'd1, 8'd1, 8'd1, 4'd1, 4'd1, 4'd1);
    step("R6 hend", 9'd9, 9'd3, 9'd2, 9'd9, 9'd3, 9'd8, 8'd1, 8'd1, 8'd1, 4'd1, 4'd1, 4'd1);
    step("R6 vend", 9'd8, 9'd8, 9'd2, 9'd9, 9'd3, 9'd8, 8'd1, 8'd1, 8'd1, 4'd1, 4'd1, 4'd1);
    step("R6 vlast", 9'd8, 9'd7, 9'd2, 9'd9, 9'd3, 9'd8, 8'd1, 8'd1, 8'd1, 4'd1, 4'd1, 4'd1);
    // R7 horizontal off
    step("R7", 9'd5, 9'd5, 9'd0, 9'd9, 9'd3, 9'd8, 8'd1, 8'd1, 8'd1, 4'd1, 4'd1, 4'd1);
    // R8 full frame, even with vertical off and empty range
    step("R8", 9'd400, 9'd0, 9'h1FF, 9'd0, 9'd0, 9'd0, 8'd1, 8'd1, 8'd1, 4'd1, 4'd1, 4'd1);
    // R9 vertical off
    step("R9", 9'd5, 9'd5, 9'd2, 9'd9, 9'd0, 9'd8, 8'd1, 8'd1, 8'd1, 4'd1, 4'd1, 4'd1);

    // R1 latency: inputs change between edges, outputs hold
    step("R1 pre", 9'd5, 9'd5, 9'd2, 9'd9, 9'd3, 9'd8, 8'd20, 8'd20, 8'd20, 4'd2, 4'd2, 4'd2);
    o_h = h_pos; o_hb = h_beg;
    @(negedge clk);
    drive(9'd5, 9'd5, 9'd0, 9'd9, 9'd3, 9'd8, 8'd7, 8'd7, 8'd7, 4'd14, 4'd14, 4'd14);
    #1;
    chk("R1 hold act", 32'(frame_act), 32'(m_act(o_h, 9'd5, o_hb, 9'd9, 9'd3, 9'd8)));
    chk("R1 hold amp", 32'(amp_r), 32'(m_amp(8'd20, 4'd2)));
    chk("R1 hold vld", 32'(vld_g), 1);
    @(negedge clk);
    check_all("R1 post");

    // random mix covering R3..R10
    seed = $urandom(32'd13579);
    for (int i = 0; i < 400; i++) begin
      logic [8:0] hb;
      logic [8:0] vb;
      int sel;
      sel = $urandom_range(0, 9);
      hb = (sel == 0) ? 9'd0 : (sel == 1) ? 9'h1FF : 9'($urandom_range(1, 40));
      vb = (sel == 2) ? 9'd0 : 9'($urandom_range(1, 40));
      step("R6-rand", 9'($urandom_range(0, 48)), 9'($urandom_range(0, 48)),
           hb, 9'($urandom_range(0, 48)), vb, 9'($urandom_range(0, 48)),
           8'($urandom), 8'($urandom_range(0, 20)), 8'($urandom_range(0, 70)),
           4'($urandom), 4'($urandom), 4'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule